// File: doc/BRIEF.md
# Fractional-N Output Rate Calculator

This block works out the output frequency of a fractional-N synthesizer from the three packed configuration words that program it and from the frequency of its reference clock. A caller presents the divider word, the numerator word, the denominator word and the reference rate, and pulses `start`. The block latches the operands, pulls the fields out of the words and turns the small reference-divider and output-divider codes into the divide ratios they stand for. It then forms the full-width numerator and denominator of the fractional-N formula and divides them in a restoring divider that settles one quotient bit per clock.

The result is the exact integer quotient. The remainder is dropped. A denominator field of zero produces no division: the block reports a rate of zero with an error flag. A new request is only taken while the block is idle. The result and error flag stay on the outputs until the next calculation finishes.

Top module: `fracn_rate_calc`

## Requirements
- R1: After reset, `rate` is 0 and `valid` and `err` are low.
- R2: The integer multiplier is taken from bits 24:16 of `div_word`, the reference-divider code from bits 15:13 and the output-divider code from bits 7:0. Bits 31:25 and 12:8 of `div_word` do not change the result.
- R3: The fractional numerator is taken from bits 31:2 of `num_word` and the denominator from bits 29:0 of `den_word`. Bits 1:0 of `num_word` and bits 31:30 of `den_word` do not change the result.
- R4: A reference-divider code of 0 divides by 1. Codes 1 to 7 divide by their own value.
- R5: An output-divider code of 0 divides by 2 and a code of 1 divides by 3. Codes 2 to 255 divide by their own value.
- R6: `rate` equals floor((Fref·MFI·MFD + Fref·MFN) / (MFD·rdiv·odiv)) at full width with no overflow. For example, Fref = 24 MHz, MFI = 81, MFN = 0, MFD = 1, reference code 0 and output code 3 give 648 MHz.
- R7: A zero denominator field completes with `rate` = 0 and `err` = 1. A calculation with a nonzero denominator completes with `err` = 0.
- R8: `valid` is high for exactly one cycle per calculation. `rate` and `err` hold their values until the next calculation completes.
- R9: A `start` pulse that arrives while a calculation is in progress is ignored. Exactly one `valid` pulse follows, and its result comes from the operands captured at the accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request a calculation; taken only when idle |
| div_word | input | 32 | Packed integer-multiplier and divider-code word |
| num_word | input | 32 | Packed fractional-numerator word |
| den_word | input | 32 | Packed denominator word |
| ref_rate | input | REF_W (32) | Reference frequency in Hz |
| rate | output | REF_W+40 (72) | Computed output frequency in Hz |
| valid | output | 1 | One-cycle pulse when `rate`/`err` are updated |
| err | output | 1 | Last calculation had a zero denominator |

## Verification
The assertions rely on one property of the inputs: the divider is only launched with a nonzero divisor. That holds because the reference-divider and output-divider codes always map to nonzero ratios, and the zero-denominator case is routed around the divider. The stimulus covers every reference-divider code against a spread of output-divider codes, including 0, 1 and 255. It also covers random words with their unused bits set and zero denominators, the zero case placed both in clean words and behind set upper bits. It never holds `start` across a `valid` pulse, except in the one test that deliberately issues `start` mid-calculation.

// File: rtl/fracn_rate_pkg.sv
// Package: register field layout and controller state shared by the
// fractional-N rate calculator. Assumes 32-bit configuration words.
package fracn_rate_pkg;
    localparam int WORD_W   = 32;
    // Divider word fields
    localparam int MFI_LSB  = 16;
    localparam int MFI_W    = 9;
    localparam int RDIV_LSB = 13;
    localparam int RDIV_W   = 3;
    localparam int ODIV_LSB = 0;
    localparam int ODIV_W   = 8;
    // Numerator / denominator fields
    localparam int MFN_LSB  = 2;
    localparam int MFD_LSB  = 0;
    localparam int FRAC_W   = 30;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PREP   = 2'd1,
        ST_DIVIDE = 2'd2
    } calc_state_t;
endpackage

// File: rtl/fracn_field_decode.sv
// Module: fracn_field_decode
// Extracts the multiplier, numerator and denominator fields from the packed
// words and maps the divider codes to their ratios (reference code 0 -> 1,
// output code 0 -> 2, output code 1 -> 3). Purely combinational; assumes
// the field layout in fracn_rate_pkg.
module fracn_field_decode
    import fracn_rate_pkg::*;
(
    input  logic [WORD_W-1:0] div_word,
    input  logic [WORD_W-1:0] num_word,
    input  logic [WORD_W-1:0] den_word,
    output logic [MFI_W-1:0]  mfi,
    output logic [FRAC_W-1:0] mfn,
    output logic [FRAC_W-1:0] mfd,
    output logic [RDIV_W-1:0] rdiv_ratio,
    output logic [ODIV_W-1:0] odiv_ratio,
    output logic              den_zero
);
    logic [RDIV_W-1:0] rdiv_code;
    logic [ODIV_W-1:0] odiv_code;
    logic              unused_bits;

    // Slice the fields out of the packed words.
    always_comb begin
        mfi       = div_word[MFI_LSB +: MFI_W];
        rdiv_code = div_word[RDIV_LSB +: RDIV_W];
        odiv_code = div_word[ODIV_LSB +: ODIV_W];
        mfn       = num_word[MFN_LSB +: FRAC_W];
        mfd       = den_word[MFD_LSB +: FRAC_W];
        den_zero  = (mfd == '0);
    end

    // Map the reference-divider code: zero means divide by one.
    always_comb begin
        if (rdiv_code == '0) rdiv_ratio = RDIV_W'(1);
        else                 rdiv_ratio = rdiv_code;
    end

    // Map the output-divider code: 0 -> 2, 1 -> 3, others unchanged.
    always_comb begin
        case (odiv_code)
            ODIV_W'(0): odiv_ratio = ODIV_W'(2);
            ODIV_W'(1): odiv_ratio = ODIV_W'(3);
            default:    odiv_ratio = odiv_code;
        endcase
    end

    // Reserved bits are deliberately unused.
    assign unused_bits = ^{div_word[WORD_W-1:MFI_LSB+MFI_W],
                           div_word[RDIV_LSB-1:ODIV_LSB+ODIV_W],
                           num_word[MFN_LSB-1:0],
                           den_word[WORD_W-1:MFD_LSB+FRAC_W]};
endmodule

// File: rtl/fracn_operand_build.sv
// Module: fracn_operand_build
// Forms the dividend Fref*MFI*MFD + Fref*MFN and the divisor MFD*rdiv*odiv
// at widths that cannot overflow. Combinational; fed from captured registers.
module fracn_operand_build
    import fracn_rate_pkg::*;
#(
    parameter int REF_W = 32,
    localparam int NUM_W = REF_W + MFI_W + FRAC_W + 1,
    localparam int DEN_W = FRAC_W + RDIV_W + ODIV_W
)(
    input  logic [REF_W-1:0]  ref_rate,
    input  logic [MFI_W-1:0]  mfi,
    input  logic [FRAC_W-1:0] mfn,
    input  logic [FRAC_W-1:0] mfd,
    input  logic [RDIV_W-1:0] rdiv_ratio,
    input  logic [ODIV_W-1:0] odiv_ratio,
    output logic [NUM_W-1:0]  dividend,
    output logic [DEN_W-1:0]  divisor
);
    logic [NUM_W-1:0] int_part;
    logic [NUM_W-1:0] frac_part;

    // Integer and fractional contributions to the scaled VCO rate.
    always_comb begin
        int_part  = NUM_W'(ref_rate) * NUM_W'(mfi) * NUM_W'(mfd);
        frac_part = NUM_W'(ref_rate) * NUM_W'(mfn);
        dividend  = int_part + frac_part;
    end

    // Total division ratio including the fractional denominator.
    always_comb begin
        divisor = DEN_W'(mfd) * DEN_W'(rdiv_ratio) * DEN_W'(odiv_ratio);
    end
endmodule

// File: rtl/fracn_restoring_div.sv
// Module: fracn_restoring_div
// Unsigned restoring divider producing one quotient bit per cycle. A go
// pulse while idle loads the operands; NUM_W cycles later done pulses once
// and quotient holds the result. Assumes a nonzero divisor at go.
module fracn_restoring_div #(
    parameter int NUM_W = 72,
    parameter int DEN_W = 41,
    localparam int CNT_W = $clog2(NUM_W + 1)
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [NUM_W-1:0] dividend,
    input  logic [DEN_W-1:0] divisor,
    output logic [NUM_W-1:0] quotient,
    output logic             done
);
    logic [NUM_W-1:0] quo_q;
    logic [DEN_W-1:0] rem_q;
    logic [DEN_W-1:0] dsr_q;
    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;
    logic             done_q;
    logic [DEN_W:0]   rem_shift;
    logic [DEN_W:0]   trial;
    logic             fits;

    // One trial subtraction of the shifted partial remainder.
    always_comb begin
        rem_shift = {rem_q, quo_q[NUM_W-1]};
        trial     = rem_shift - {1'b0, dsr_q};
        fits      = ~trial[DEN_W];
    end

    // Iteration register: load on go, then shift in one quotient bit a cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quo_q  <= '0;
            rem_q  <= '0;
            dsr_q  <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (go && !busy_q) begin
                quo_q  <= dividend;
                rem_q  <= '0;
                dsr_q  <= divisor;
                cnt_q  <= CNT_W'(NUM_W);
                busy_q <= 1'b1;
            end else if (busy_q) begin
                rem_q <= fits ? trial[DEN_W-1:0] : rem_shift[DEN_W-1:0];
                quo_q <= {quo_q[NUM_W-2:0], fits};
                cnt_q <= cnt_q - CNT_W'(1);
                if (cnt_q == CNT_W'(1)) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign quotient = quo_q;
    assign done     = done_q;

    // R6: partial remainder always stays below the divisor while iterating
    assert_rem_below_divisor_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (rem_q < dsr_q));
    // R7: the divider is never launched with a zero divisor
    assert_nonzero_divisor_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !busy_q) |-> (divisor != '0));
    // R8: completion is a single-cycle pulse
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
endmodule

// File: rtl/fracn_rate_calc.sv
// Module: fracn_rate_calc (top)
// Latches the configuration words on an accepted start, builds the
// fractional-N operands and divides them. Zero denominators bypass the
// divider and complete with rate 0 and err set. Start is ignored unless idle.
module fracn_rate_calc
    import fracn_rate_pkg::*;
#(
    parameter int REF_W = 32,
    localparam int NUM_W = REF_W + MFI_W + FRAC_W + 1,
    localparam int DEN_W = FRAC_W + RDIV_W + ODIV_W
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] div_word,
    input  logic [WORD_W-1:0] num_word,
    input  logic [WORD_W-1:0] den_word,
    input  logic [REF_W-1:0]  ref_rate,
    output logic [NUM_W-1:0]  rate,
    output logic              valid,
    output logic              err
);
    calc_state_t       state_q;
    logic [MFI_W-1:0]  mfi_d,  mfi_q;
    logic [FRAC_W-1:0] mfn_d,  mfn_q;
    logic [FRAC_W-1:0] mfd_d,  mfd_q;
    logic [RDIV_W-1:0] rdiv_d, rdiv_q;
    logic [ODIV_W-1:0] odiv_d, odiv_q;
    logic              zero_d, zero_q;
    logic [REF_W-1:0]  ref_q;
    logic [NUM_W-1:0]  dividend;
    logic [DEN_W-1:0]  divisor;
    logic [NUM_W-1:0]  quotient;
    logic              div_go;
    logic              div_done;
    logic [NUM_W-1:0]  rate_q;
    logic              valid_q;
    logic              err_q;

    fracn_field_decode u_decode (
        .div_word   (div_word),
        .num_word   (num_word),
        .den_word   (den_word),
        .mfi        (mfi_d),
        .mfn        (mfn_d),
        .mfd        (mfd_d),
        .rdiv_ratio (rdiv_d),
        .odiv_ratio (odiv_d),
        .den_zero   (zero_d)
    );

    fracn_operand_build #(.REF_W(REF_W)) u_operands (
        .ref_rate   (ref_q),
        .mfi        (mfi_q),
        .mfn        (mfn_q),
        .mfd        (mfd_q),
        .rdiv_ratio (rdiv_q),
        .odiv_ratio (odiv_q),
        .dividend   (dividend),
        .divisor    (divisor)
    );

    fracn_restoring_div #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (div_go),
        .dividend (dividend),
        .divisor  (divisor),
        .quotient (quotient),
        .done     (div_done)
    );

    // Launch the divider from the prepare state when the denominator is valid.
    assign div_go = (state_q == ST_PREP) && !zero_q;

    // Operand capture: only an idle start updates the latched fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mfi_q  <= '0;
            mfn_q  <= '0;
            mfd_q  <= '0;
            rdiv_q <= '0;
            odiv_q <= '0;
            zero_q <= 1'b0;
            ref_q  <= '0;
        end else if (state_q == ST_IDLE && start) begin
            mfi_q  <= mfi_d;
            mfn_q  <= mfn_d;
            mfd_q  <= mfd_d;
            rdiv_q <= rdiv_d;
            odiv_q <= odiv_d;
            zero_q <= zero_d;
            ref_q  <= ref_rate;
        end
    end

    // Sequencer and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rate_q  <= '0;
            valid_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) state_q <= ST_PREP;
                end
                ST_PREP: begin
                    if (zero_q) begin
                        rate_q  <= '0;
                        err_q   <= 1'b1;
                        valid_q <= 1'b1;
                        state_q <= ST_IDLE;
                    end else begin
                        state_q <= ST_DIVIDE;
                    end
                end
                ST_DIVIDE: begin
                    if (div_done) begin
                        rate_q  <= quotient;
                        err_q   <= 1'b0;
                        valid_q <= 1'b1;
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign rate  = rate_q;
    assign valid = valid_q;
    assign err   = err_q;

    // R8: valid never lasts more than one cycle
    assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);
    // R8: outputs hold between completions
    assert_rate_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |=> ($stable(rate) && $stable(err)) || valid);
    // R7: an error completion reports a zero rate
    assert_err_zero_rate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && err) |-> (rate == '0));
    // R9: latched operands stay fixed while a calculation is running
    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> ($stable(ref_q) && $stable(mfd_q) && $stable(mfn_q)
                                  && $stable(mfi_q) && $stable(odiv_q) && $stable(rdiv_q)));
    // R9: a completion only follows a calculation in progress
    assert_valid_after_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid) |-> ($past(state_q) != ST_IDLE));
endmodule

// File: tb/tb_fracn_rate_calc.sv
module tb_fracn_rate_calc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] div_word = '0;
    logic [31:0] num_word = '0;
    logic [31:0] den_word = '0;
    logic [31:0] ref_rate = '0;
    logic [71:0] rate;
    logic        valid;
    logic        err;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    fracn_rate_calc dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .div_word(div_word), .num_word(num_word), .den_word(den_word),
        .ref_rate(ref_rate), .rate(rate), .valid(valid), .err(err)
    );

    always #2.5 clk = ~clk;

    // Watchdog
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++;
                $display("FAIL watchdog: act %0d cycles exp < 150000", cycles);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    function automatic logic [127:0] model(input logic [31:0] d, n, m, r);
        logic [127:0] mfi, mfn, mfd, rdv, odv;
        mfi = 128'(d[24:16]);
        rdv = (d[15:13] == 3'd0) ? 128'd1 : 128'(d[15:13]);
        odv = (d[7:0] == 8'd0) ? 128'd2 : (d[7:0] == 8'd1) ? 128'd3 : 128'(d[7:0]);
        mfn = 128'(n[31:2]);
        mfd = 128'(m[29:0]);
        if (mfd == 0) return 128'd0;
        return (128'(r) * mfi * mfd + 128'(r) * mfn) / (mfd * rdv * odv);
    endfunction

    function automatic logic [31:0] mk_div(input int mfi, input int rc, input int oc);
        return {7'h0, 9'(mfi), 3'(rc), 5'h0, 8'(oc)};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: act %0d exp %0d", req, act, exp);
        end
    endtask

    task automatic run_calc(input logic [31:0] d, n, m, r,
                            output logic [71:0] got, output logic got_err, output bit seen);
        int waited;
        @(negedge clk);
        div_word = d; num_word = n; den_word = m; ref_rate = r; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        seen = 0; waited = 0; got = '0; got_err = 1'b0;
        while (!seen && waited < 400) begin
            if (valid) begin
                seen = 1; got = rate; got_err = err;
            end else begin
                @(negedge clk);
                waited++;
            end
        end
    endtask

    task automatic check_case(input logic [31:0] d, n, m, r, input string req);
        logic [71:0] got; logic ge; bit seen;
        logic [127:0] exp;
        exp = model(d, n, m, r);
        run_calc(d, n, m, r, got, ge, seen);
        chk(seen && (128'(got) == exp), req, 128'(got), exp);
        chk(seen && (ge == (m[29:0] == 30'd0)), {req, " err"}, 128'(ge), 128'(m[29:0] == 30'd0));
    endtask

    initial begin
        logic [71:0] ga, gb; logic ea, eb; bit sa, sb;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(rate == '0, "R1 rate", 128'(rate), 0);
        chk(!valid && !err, "R1 flags", {valid, err}, 0);

        // R6: worked example, 24 MHz * 81 / 3 = 648 MHz
        run_calc(mk_div(81, 0, 3), 32'd0, 32'd1, 32'd24_000_000, ga, ea, sa);
        chk(sa && ga == 72'd648_000_000, "R6 example", 128'(ga), 128'd648_000_000);

        // R4/R5/R6: every reference code against a spread of output codes
        for (int rc = 0; rc < 8; rc++) begin
            for (int k = 0; k < 6; k++) begin
                int oc;
                oc = (k == 0) ? 0 : (k == 1) ? 1 : (k == 2) ? 2 : (k == 3) ? 3 : (k == 4) ? 7 : 255;
                check_case(mk_div(81, rc, oc), {30'd92, 2'b00}, 32'd100, 32'd24_000_000, "R6 sweep");
            end
        end

        // R4: code 0 behaves as code 1
        run_calc(mk_div(167, 0, 9), 32'd0, 32'd1, 32'd24_000_000, ga, ea, sa);
        run_calc(mk_div(167, 1, 9), 32'd0, 32'd1, 32'd24_000_000, gb, eb, sb);
        chk(sa && sb && ga == gb, "R4 code0==code1", 128'(ga), 128'(gb));

        // R5: output code 0 equals code 2, code 1 equals code 3
        run_calc(mk_div(50, 0, 0), 32'd0, 32'd1, 32'd24_000_000, ga, ea, sa);
        run_calc(mk_div(50, 0, 2), 32'd0, 32'd1, 32'd24_000_000, gb, eb, sb);
        chk(sa && sb && ga == gb && ga == 72'd600_000_000, "R5 code0 div2", 128'(ga), 128'(gb));
        run_calc(mk_div(50, 0, 1), 32'd0, 32'd1, 32'd24_000_000, ga, ea, sa);
        run_calc(mk_div(50, 0, 3), 32'd0, 32'd1, 32'd24_000_000, gb, eb, sb);
        chk(sa && sb && ga == gb && ga == 72'd400_000_000, "R5 code1 div3", 128'(ga), 128'(gb));

        // R2/R3: reserved bits set must not change the result
        run_calc(mk_div(81, 0, 5), {30'd92, 2'b00}, 32'd100, 32'd24_000_000, ga, ea, sa);
        run_calc(mk_div(81, 0, 5) | 32'hFE00_1F00, {30'd92, 2'b11}, 32'hC000_0064, 32'd24_000_000, gb, eb, sb);
        chk(sa && sb && ga == gb, "R2 R3 reserved bits", 128'(gb), 128'(ga));

        // R2/R3/R6: random words, full-range fields and reference
        for (int i = 0; i < 80; i++) begin
            logic [31:0] d, n, m, r;
            d = $urandom; n = $urandom; m = $urandom; r = $urandom;
            if (i % 4 == 0) r = 32'hFFFF_FFFF;
            if (i % 8 == 1) m = 32'h3FFF_FFFF;
            if (m[29:0] == 30'd0) m = 32'd1;
            check_case(d, n, m, r, "R6 random");
        end

        // R7: zero denominator, plain and behind set reserved bits
        check_case(mk_div(81, 2, 4), {30'd5, 2'b00}, 32'd0, 32'd24_000_000, "R7 zero den");
        check_case(mk_div(81, 2, 4), {30'd5, 2'b00}, 32'hC000_0000, 32'd24_000_000, "R7 zero den hi");
        // R7: error clears on the next good result
        run_calc(mk_div(81, 0, 3), 32'd0, 32'd1, 32'd24_000_000, ga, ea, sa);
        chk(sa && !ea && ga == 72'd648_000_000, "R7 err clears", 128'(ea), 0);

        // R8: single pulse and held outputs
        begin
            int pulses;
            pulses = 0;
            repeat (6) begin
                @(negedge clk);
                if (valid) pulses++;
            end
            chk(pulses == 0, "R8 single pulse", pulses, 0);
            chk(rate == 72'd648_000_000 && !err, "R8 hold", 128'(rate), 128'd648_000_000);
        end

        // R9: start mid-calculation is ignored
        begin
            int pulses; logic [71:0] first;
            logic [31:0] da;
            da = mk_div(121, 0, 6);
            @(negedge clk);
            div_word = da; num_word = 32'd0; den_word = 32'd1; ref_rate = 32'd24_000_000; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            repeat (10) @(negedge clk);
            div_word = mk_div(50, 0, 3); den_word = 32'd0; ref_rate = 32'd1; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            pulses = 0; first = '0;
            repeat (300) begin
                @(negedge clk);
                if (valid) begin
                    if (pulses == 0) first = rate;
                    pulses++;
                end
            end
            chk(pulses == 1, "R9 one completion", pulses, 1);
            chk(first == 72'd484_000_000 && !err, "R9 first operands", 128'(first), 128'd484_000_000);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule